// File: doc/BRIEF.md
# USB Pipe FIFO DMA Port Controller

This block steers a DMA-facing FIFO port onto one pipe of a multi-pipe USB packet buffer. Software picks a pipe, an access width and a set of mode bits through a small configuration write port. The block then raises a DMA request while that pipe's buffer bank can take or give data. It counts the bytes each acknowledged transfer moves, and tells the buffer side when a packet is complete.

On a send pipe, a full packet is committed automatically. The DMA controller's transfer-end strobe can also commit a short final packet, just as a software buffer-valid write would. When the data ended exactly on a packet boundary, the strobe can queue one zero-length packet instead. On a receive pipe, the block can clear the pipe's buffer once the received packet has been read out. If the buffer-ready mode bit is set, the clear also waits for the short-packet or transfer-length event to be acknowledged. The protocol engine, the DMA controller and the buffer RAM are outside this block.

Top module: `usb_dma_fifo_port`

## Requirements
- R1: Only pipes 1 to 7 are served. While pipe 0 is selected, which is also the reset value, `dreq_o` stays low and acknowledges and end strobes have no effect.
- R2: `dreq_o` is high when three things hold: a valid pipe is selected, `buf_ready_i` of that pipe is high, and the pipe is not held after a packet boundary.
- R3: Width code 0 moves 1 byte per acknowledge, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes.
- R4: On a send pipe, the acknowledge that brings the byte count to `maxp_i` or beyond commits the packet: `commit_o` pulses in the next cycle and the count restarts from 0. `dreq_o` drops in the same cycle as that acknowledge. It stays low until that pipe's `buf_ready_i` has been low for at least one cycle.
- R5: A transfer is busy from its first accepted acknowledge until `dend_i`. A configuration write that arrives while the transfer is busy is ignored in all its fields. If the write named a different pipe, `sel_err_o` pulses in the next cycle.
- R6: When end sampling is enabled and `dend_i` arrives on a send pipe with a nonzero partial count, `commit_o` pulses in the next cycle. When end sampling is disabled, `dend_i` commits nothing.
- R7: The zero-length mode applies to a send pipe with end sampling enabled. In that case, a `dend_i` that arrives while the count is 0 after at least one transfer pulses `zlp_o` in the next cycle. A `dend_i` that arrives mid-packet gives no `zlp_o`.
- R8: On a receive pipe, the acknowledge that brings the bytes read to `rx_cnt_i` or beyond completes the read. `dreq_o` drops in that cycle and is held as in R4.
- R9: With auto-clear set and the buffer-ready mode bit clear, `clr_o` pulses in the cycle after the read completes.
- R10: With auto-clear set and the buffer-ready mode bit set, `clr_o` pulses once, in the cycle after both the read has completed and `evt_done_i` has been seen, in either order.
- R11: Zero-length mode on a receive pipe, and auto-clear on a send pipe, have no effect.
- R12: After reset, `cur_pipe_o` is 0 and `commit_o`, `zlp_o`, `clr_o` and `sel_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_pipe_i | input | 3 | Pipe to select |
| cfg_width_i | input | 2 | Access width code |
| cfg_tend_en_i | input | 1 | Sample DMA end strobe |
| cfg_zlp_en_i | input | 1 | Zero-length packet mode |
| cfg_aclr_en_i | input | 1 | Receive auto-clear mode |
| cfg_bfre_i | input | 1 | Buffer-ready mode: auto-clear waits for event |
| pipe_tx_i | input | 8 | Per-pipe direction, 1 = send |
| buf_ready_i | input | 8 | Per-pipe bank accessible |
| maxp_i | input | 11 | Max packet size of selected pipe |
| rx_cnt_i | input | 11 | Received byte length of selected pipe |
| dack_i | input | 1 | DMA acknowledge, one transfer |
| dend_i | input | 1 | DMA transfer-end strobe |
| evt_done_i | input | 1 | Short-packet or length event handled |
| dreq_o | output | 1 | DMA request |
| cur_pipe_o | output | 3 | Currently selected pipe |
| commit_o | output | 1 | Release send buffer for transmission |
| zlp_o | output | 1 | Queue one zero-length packet |
| clr_o | output | 1 | Clear receive buffer |
| sel_err_o | output | 1 | Pipe change refused during transfer |

## Verification
The assertions check several rules on every cycle. No request is raised for pipe 0. The request falls after a fill or drain. The pipe stays locked while a transfer is busy. Commit and zero-length pulses come only from send pipes, and clear pulses only from receive pipes with auto-clear armed.

Some behaviour can only be shown by the bench's scenarios. These are the exact commit and zero-length counts for each width and length pattern, and the end strobe landing on a boundary versus mid-packet. The bench also covers the two orderings of read completion and event acknowledge under buffer-ready mode.

// File: rtl/usb_dfp_pkg.sv
package usb_dfp_pkg;
  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2,
    W_WALT = 2'd3
  } acc_width_e;

  typedef struct packed {
    acc_width_e width;
    logic       tend_en;
    logic       zlp_en;
    logic       aclr_en;
    logic       bfre;
  } port_mode_t;

  function automatic logic [2:0] width_bytes(acc_width_e w);
    case (w)
      W_BYTE:  width_bytes = 3'd1;
      W_HALF:  width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dfp_cfg_regs.sv
module dfp_cfg_regs
  import usb_dfp_pkg::*;
#(
  parameter int PIPE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PIPE_W-1:0] pipe_i,
  input  port_mode_t        mode_i,
  input  logic              busy_i,
  output logic [PIPE_W-1:0] pipe_o,
  output port_mode_t        mode_o,
  output logic              restart_o,
  output logic              err_o
);
  logic [PIPE_W-1:0] pipe_q;
  port_mode_t        mode_q;
  logic              err_q;

  assign restart_o = we_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= we_i & busy_i & (pipe_i != pipe_q);
      if (restart_o) begin
        pipe_q <= pipe_i;
        mode_q <= mode_i;
      end
    end
  end

  assign pipe_o = pipe_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;

  p_pipe_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(pipe_o));
endmodule

// File: rtl/dfp_xfer_cnt.sv
module dfp_xfer_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_en_i,
  input  logic [2:0]       step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_after_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum         = {1'b0, cnt_q} + {{(CNT_W-2){1'b0}}, step_i};
  assign hit_o       = step_en_i & (sum >= {1'b0, limit_i});
  assign cnt_after_o = hit_o ? '0 : (step_en_i ? sum[CNT_W-1:0] : cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_after_o;
  end
endmodule

// File: rtl/dfp_tx_ctl.sv
module dfp_tx_ctl #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_i,
  input  logic             end_i,
  input  logic             zlp_en_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] cnt_after_i,
  output logic             release_o,
  output logic             commit_o,
  output logic             zlp_o
);
  logic commit_q, zlp_q;

  // short packet released by end strobe
  assign release_o = tx_i & end_i & (cnt_after_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b0;
      zlp_q    <= 1'b0;
    end else begin
      commit_q <= (tx_i & hit_i) | release_o;
      zlp_q    <= tx_i & zlp_en_i & end_i & (cnt_after_i == '0);
    end
  end

  assign commit_o = commit_q;
  assign zlp_o    = zlp_q;

  p_commit_tx_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(tx_i));
  p_zlp_tx_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zlp_o |-> $past(tx_i && zlp_en_i && end_i));
endmodule

// File: rtl/dfp_rx_clr.sv
module dfp_rx_clr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic aclr_i,
  input  logic bfre_i,
  input  logic done_i,
  input  logic evt_i,
  output logic clr_o
);
  logic rd_pend_q, ev_pend_q, clr_q;
  logic rd_any, ev_any, fire;

  assign rd_any = rd_pend_q | done_i;
  assign ev_any = ev_pend_q | evt_i;
  assign fire   = aclr_i & (bfre_i ? (rd_any & ev_any) : done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      ev_pend_q <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      clr_q <= fire;
      if (restart_i || fire || !(aclr_i && bfre_i)) begin
        rd_pend_q <= 1'b0;
        ev_pend_q <= 1'b0;
      end else begin
        rd_pend_q <= rd_any;
        ev_pend_q <= ev_any;
      end
    end
  end

  assign clr_o = clr_q;

  p_clr_armed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> $past(aclr_i));
  p_clr_waits_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o && $past(bfre_i)) |-> $past(rd_pend_q || done_i));
endmodule

// File: rtl/usb_dma_fifo_port.sv
module usb_dma_fifo_port
  import usb_dfp_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int CNT_W     = 11,
  localparam int PIPE_W   = $clog2(NUM_PIPES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [PIPE_W-1:0]    cfg_pipe_i,
  input  logic [1:0]           cfg_width_i,
  input  logic                 cfg_tend_en_i,
  input  logic                 cfg_zlp_en_i,
  input  logic                 cfg_aclr_en_i,
  input  logic                 cfg_bfre_i,
  input  logic [NUM_PIPES-1:0] pipe_tx_i,
  input  logic [NUM_PIPES-1:0] buf_ready_i,
  input  logic [CNT_W-1:0]     maxp_i,
  input  logic [CNT_W-1:0]     rx_cnt_i,
  input  logic                 dack_i,
  input  logic                 dend_i,
  input  logic                 evt_done_i,
  output logic                 dreq_o,
  output logic [PIPE_W-1:0]    cur_pipe_o,
  output logic                 commit_o,
  output logic                 zlp_o,
  output logic                 clr_o,
  output logic                 sel_err_o
);
  port_mode_t        mode_in, mode;
  logic [PIPE_W-1:0] sel;
  logic              restart, sel_ok, is_tx, ready;
  logic              busy_q, hold_q, dack_ok, end_s, hit, release_s;
  logic [CNT_W-1:0]  limit, cnt_after;

  assign mode_in = '{width:   acc_width_e'(cfg_width_i),
                     tend_en: cfg_tend_en_i,
                     zlp_en:  cfg_zlp_en_i,
                     aclr_en: cfg_aclr_en_i,
                     bfre:    cfg_bfre_i};

  dfp_cfg_regs #(.PIPE_W(PIPE_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .pipe_i(cfg_pipe_i), .mode_i(mode_in), .busy_i(busy_q),
    .pipe_o(sel), .mode_o(mode), .restart_o(restart), .err_o(sel_err_o)
  );

  assign sel_ok  = (sel != '0);
  assign is_tx   = pipe_tx_i[sel];
  assign ready   = buf_ready_i[sel];
  assign dack_ok = dack_i & sel_ok;
  assign end_s   = dend_i & sel_ok & mode.tend_en & (busy_q | dack_ok);
  assign limit   = is_tx ? maxp_i : rx_cnt_i;

  dfp_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i(restart | (end_s & is_tx)),
    .step_en_i(dack_ok),
    .step_i(width_bytes(mode.width)),
    .limit_i(limit),
    .hit_o(hit),
    .cnt_after_o(cnt_after)
  );

  dfp_tx_ctl #(.CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni,
    .tx_i(is_tx), .end_i(end_s), .zlp_en_i(mode.zlp_en),
    .hit_i(hit), .cnt_after_i(cnt_after),
    .release_o(release_s), .commit_o(commit_o), .zlp_o(zlp_o)
  );

  dfp_rx_clr u_rx (
    .clk_i, .rst_ni,
    .restart_i(restart),
    .aclr_i(mode.aclr_en & ~is_tx & sel_ok),
    .bfre_i(mode.bfre),
    .done_i(hit & ~is_tx),
    .evt_i(evt_done_i),
    .clr_o(clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (dend_i)       busy_q <= 1'b0;
      else if (dack_ok) busy_q <= 1'b1;
      // hold until bank handover seen as ready low
      if (restart)                 hold_q <= 1'b0;
      else if (hit || release_s)   hold_q <= 1'b1;
      else if (!ready)             hold_q <= 1'b0;
    end
  end

  assign dreq_o     = sel_ok & ready & ~hold_q & ~hit;
  assign cur_pipe_o = sel;

  p_pipe0_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_pipe_o == '0) |-> !dreq_o);
  p_fill_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !cfg_we_i) |=> !dreq_o);
  p_no_ready_no_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_ready_i[cur_pipe_o] |-> !dreq_o);
  p_excl_pulses_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_o && (commit_o || zlp_o)));
endmodule

// File: tb/sim_usb_dma_fifo_port.sv
module sim_usb_dma_fifo_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_pipe_i = '0;
  logic [1:0]  cfg_width_i = '0;
  logic        cfg_tend_en_i = 1'b0, cfg_zlp_en_i = 1'b0;
  logic        cfg_aclr_en_i = 1'b0, cfg_bfre_i = 1'b0;
  logic [7:0]  pipe_tx_i = 8'b0111_1110;
  logic [7:0]  buf_ready_i = 8'hFF;
  logic [10:0] maxp_i = 11'd8, rx_cnt_i = 11'd6;
  logic        dack_i = 1'b0, dend_i = 1'b0, evt_done_i = 1'b0;
  logic        dreq_o, commit_o, zlp_o, clr_o, sel_err_o;
  logic [2:0]  cur_pipe_o;

  always #2 clk_i = ~clk_i;

  usb_dma_fifo_port u0 (.*);

  int n_commit = 0, n_zlp = 0, n_clr = 0;
  always @(negedge clk_i) begin
    if (commit_o) n_commit++;
    if (zlp_o)    n_zlp++;
    if (clr_o)    n_clr++;
  end

  int total = 0, bad = 0;
  int s_commit, s_zlp, s_clr;
  bit wd = 1'b0;

  // width, maxp, dacks, tend, zlp
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0,  8, 8, 1, 1},
    '{0,  8, 8, 1, 0},
    '{1,  8, 5, 1, 1},
    '{2, 16, 8, 1, 1},
    '{3,  8, 3, 1, 0},
    '{2, 64, 3, 0, 1}
  };

  function automatic int wb(int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_commit = n_commit; s_zlp = n_zlp; s_clr = n_clr;
  endtask

  task automatic cfg(int p, int w, bit te, bit ze, bit ae, bit bf);
    cfg_pipe_i = 3'(p); cfg_width_i = 2'(w);
    cfg_tend_en_i = te; cfg_zlp_en_i = ze; cfg_aclr_en_i = ae; cfg_bfre_i = bf;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    #1;
  endtask

  task automatic xfer();
    if (!dreq_o) begin
      buf_ready_i = 8'h00;
      @(negedge clk_i);
      buf_ready_i = 8'hFF;
      #1;
    end
    dack_i = 1'b1;
    @(negedge clk_i);
    dack_i = 1'b0;
    #1;
  endtask

  task automatic fin();
    dend_i = 1'b1;
    @(negedge clk_i);
    dend_i = 1'b0;
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R12 reset state
    chk("R12 cur_pipe", int'(cur_pipe_o), 0);
    chk("R12 commit", int'(commit_o), 0);
    chk("R12 zlp", int'(zlp_o), 0);
    chk("R12 clr", int'(clr_o), 0);
    chk("R12 sel_err", int'(sel_err_o), 0);

    // R1 pipe 0 never requests, ignores strobes
    cfg(0, 0, 1, 1, 0, 0);
    chk("R1 no dreq on pipe0", int'(dreq_o), 0);
    snap();
    xfer(); fin(); idle(2);
    chk("R1 no commit on pipe0", n_commit - s_commit, 0);
    chk("R1 no zlp on pipe0", n_zlp - s_zlp, 0);

    // R3 R6 R7 vector table
    for (int i = 0; i < NV; i++) begin
      int bytes, ec, ez;
      maxp_i = 11'(VEC[i][1]);
      cfg(i + 1, VEC[i][0], VEC[i][3] != 0, VEC[i][4] != 0, 1'b0, 1'b0);
      chk("R2 dreq on ready pipe", int'(dreq_o), 1);
      snap();
      for (int k = 0; k < VEC[i][2]; k++) xfer();
      fin();
      idle(3);
      bytes = VEC[i][2] * wb(VEC[i][0]);
      ec = bytes / VEC[i][1] + ((VEC[i][3] != 0 && bytes % VEC[i][1] != 0) ? 1 : 0);
      ez = (VEC[i][3] != 0 && VEC[i][4] != 0 && bytes % VEC[i][1] == 0) ? 1 : 0;
      chk($sformatf("R3 R6 commits vec%0d", i), n_commit - s_commit, ec);
      chk($sformatf("R7 zlp vec%0d", i), n_zlp - s_zlp, ez);
    end

    // R4 fill-cycle drop and hold
    maxp_i = 11'd8;
    cfg(1, 2, 0, 0, 0, 0);
    xfer();
    dack_i = 1'b1;
    #1;
    chk("R4 dreq low in fill cycle", int'(dreq_o), 0);
    @(negedge clk_i);
    dack_i = 1'b0;
    #1;
    chk("R4 commit pulse", int'(commit_o), 1);
    chk("R4 held with ready high", int'(dreq_o), 0);
    buf_ready_i = 8'h00;
    @(negedge clk_i);
    buf_ready_i = 8'hFF;
    #1;
    chk("R4 dreq back after toggle", int'(dreq_o), 1);
    fin();

    // R5 pipe locked while busy
    maxp_i = 11'd64;
    cfg(1, 2, 0, 0, 0, 0);
    xfer();
    cfg(3, 0, 0, 0, 0, 0);
    chk("R5 sel_err pulse", int'(sel_err_o), 1);
    chk("R5 pipe kept", int'(cur_pipe_o), 1);
    fin();
    cfg(3, 0, 0, 0, 0, 0);
    chk("R5 pipe taken when idle", int'(cur_pipe_o), 3);
    chk("R5 no err when idle", int'(sel_err_o), 0);

    // R8 R9 auto-clear, buffer-ready mode clear
    rx_cnt_i = 11'd6;
    cfg(7, 1, 0, 0, 1, 0);
    snap();
    xfer(); xfer();
    dack_i = 1'b1;
    #1;
    chk("R8 dreq low on drain", int'(dreq_o), 0);
    @(negedge clk_i);
    dack_i = 1'b0;
    #1;
    chk("R9 clr after read", int'(clr_o), 1);
    chk("R8 held after drain", int'(dreq_o), 0);
    fin();

    // R10 read first, event later
    cfg(7, 1, 0, 0, 1, 1);
    snap();
    xfer(); xfer(); xfer();
    idle(3);
    chk("R10 no clr before event", n_clr - s_clr, 0);
    evt_done_i = 1'b1;
    @(negedge clk_i);
    evt_done_i = 1'b0;
    #1;
    chk("R10 clr after event", int'(clr_o), 1);
    fin();

    // R10 event first, read later
    cfg(7, 1, 0, 0, 1, 1);
    snap();
    evt_done_i = 1'b1;
    @(negedge clk_i);
    evt_done_i = 1'b0;
    idle(2);
    chk("R10 no clr before read", n_clr - s_clr, 0);
    xfer(); xfer(); xfer();
    chk("R10 clr after read", int'(clr_o), 1);
    idle(2);
    chk("R10 single clr", n_clr - s_clr, 1);
    fin();

    // R11 zlp mode on receive pipe
    cfg(7, 1, 1, 1, 0, 0);
    snap();
    xfer(); xfer(); xfer();
    fin(); idle(3);
    chk("R11 no zlp on rx pipe", n_zlp - s_zlp, 0);
    chk("R11 no commit on rx pipe", n_commit - s_commit, 0);
    chk("R11 no clr without aclr", n_clr - s_clr, 0);

    // R11 auto-clear on send pipe
    maxp_i = 11'd4;
    cfg(2, 1, 0, 0, 1, 0);
    snap();
    xfer(); xfer();
    idle(3);
    chk("R11 commit on tx pipe", n_commit - s_commit, 1);
    chk("R11 no clr on tx pipe", n_clr - s_clr, 0);
    fin();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (60000) @(posedge clk_i);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule